// File: doc/BRIEF.md
# Command-Driven SPI Transfer Engine

This block is the SPI master half of a bridge that receives a command byte and a run of data bytes over some other host link. Once the host side has filled a byte buffer and presents the command code together with the number of bytes it received, a one-cycle start strobe hands the job to this engine. It then owns the SPI pins until the job is over.

The engine reads the buffered bytes in address order and shifts each one out MSB first in SPI mode 0. It drives low the slave-select lines that the low four bits of the command name. Every byte clocked in on MISO is written back over the buffer slot of the byte just sent, so the host can read the replies from the same buffer. A single-cycle done pulse marks the end of the job. Command codes that do not name a transfer, and transfers of zero bytes, finish at once with no SPI activity.

The buffer sits outside the block as a simple dual-port RAM with one read port and one write port. Read data is expected one clock after the read enable. The SPI clock rate is set by an even divisor of the system clock.

Top module: `spi_cmd_engine`

## Requirements
- R1: A start strobe in idle with a command code from 01h to 0Fh and a nonzero count starts a transfer. Command bit i set drives ss_n[i] low for the whole transfer, and ss_n[i] stays high when bit i is clear.
- R2: A start with command code 00h or 10h to FFh, or with a count of zero, produces no select and no SCLK edge, and done pulses in the clock cycle after the start strobe.
- R3: SCLK is low whenever no byte is being shifted. While shifting, each SCLK high and low phase lasts CLK_DIV/2 system clocks, so rising edges are CLK_DIV clocks apart.
- R4: Bytes go out MSB first. MOSI holds the next bit before each SCLK rising edge and changes only when SCLK falls, never at a rising edge.
- R5: MISO is sampled on SCLK rising edges, MSB first. The byte received during slot k is written to buffer address k through the write port.
- R6: With a count N, buffer addresses 0 to N-1 are sent in increasing order, one read per byte. Read data is taken one clock after buf_rd_en. A count above MAX_LEN (default 200) is treated as MAX_LEN, and addresses at or above the count are neither sent nor written.
- R7: The selects go low CLK_DIV/2 clocks before the first SCLK rising edge and return high CLK_DIV/2 clocks after the last SCLK falling edge.
- R8: done is a one-clock pulse, and for a real transfer it is high in the same cycle in which the selects are first seen high again.
- R9: A start strobe while a transfer is in progress is ignored: the selects, byte count and data of the running transfer do not change, and no second transfer follows.
- R10: During and after synchronous reset, ss_n is all ones, SCLK and done are low, and no buffer read or write is issued, even if reset arrives mid-transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that presents cmd and len |
| cmd | input | 8 | Command code; low nibble is the select mask |
| len | input | LW (8) | Number of buffered data bytes |
| buf_rd_en | output | 1 | Buffer read request |
| buf_rd_addr | output | AW (8) | Buffer read address |
| buf_rd_data | input | DW (8) | Buffer read data, valid one clock after buf_rd_en |
| buf_wr_en | output | 1 | Buffer write request |
| buf_wr_addr | output | AW (8) | Buffer write address |
| buf_wr_data | output | DW (8) | Byte received on MISO |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | SPI serial data out |
| miso | input | 1 | SPI serial data in |
| ss_n | output | NUM_SS (4) | Active-low slave selects |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the byte boundaries, where a design that fetches the next byte too late repeats or sends stale data, and the final byte, where an off-by-one count gives eight extra or missing clocks. It targets command codes just outside the valid range (00h, 10h, FFh) and a zero count, which a loose decoder would turn into a select pulse or a stray SCLK. It checks an oversize count, which without clamping writes past the end of the buffer. It strobes start in the middle of a job, which a design without a busy guard would use to reload the mask or count. It also measures the select-to-clock and clock-to-deselect gaps and where done lands, which a mis-sequenced state machine shifts by one or more clocks.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_XFER,
    ST_TRAIL
  } eng_state_t;

  localparam int CMD_W = 8;

endpackage

// File: rtl/spi_cmd_tick.sv
module spi_cmd_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  generate
    if (HALF == 1) begin : g_every
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(HALF);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst || !run) begin
          cnt <= '0;
        end else if (cnt == CW'(HALF - 1)) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end

      assign tick = run && (cnt == CW'(HALF - 1));

      AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst) tick |=> !tick); // R3
    end
  endgenerate

endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          miso,
  output logic          sclk,
  output logic          mosi,
  output logic          rise_first,
  output logic          rise_last,
  output logic          fall_last,
  output logic [DW-1:0] rx_word
);

  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  logic [DW-1:0] tx_sr;
  logic [DW-1:0] rx_sr;
  logic [BW-1:0] bit_idx;
  logic          rise_ev;
  logic          fall_ev;

  assign rise_ev    = run && tick && !sclk;
  assign fall_ev    = run && tick && sclk;
  assign rise_first = rise_ev && (bit_idx == '0);
  assign rise_last  = rise_ev && (bit_idx == LAST_BIT);
  assign fall_last  = fall_ev && (bit_idx == LAST_BIT);
  assign rx_word    = {rx_sr[DW-2:0], miso};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      bit_idx <= '0;
    end else if (load) begin
      tx_sr   <= load_data;
      mosi    <= load_data[DW-1];
      bit_idx <= '0;
      sclk    <= 1'b0;
    end else if (rise_ev) begin
      sclk  <= 1'b1;
      rx_sr <= rx_word;
    end else if (fall_ev) begin
      sclk <= 1'b0;
      if (bit_idx != LAST_BIT) begin
        bit_idx <= bit_idx + 1'b1;
        tx_sr   <= tx_sr << 1;
        mosi    <= tx_sr[DW-2];
      end
    end
  end

  AST_MOSI_AT_RISE: assert property (@(posedge clk) disable iff (rst) $rose(sclk) |-> $stable(mosi)); // R4
  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (rst) !run |-> !sclk); // R3

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int DW      = 8,
  parameter int MAX_LEN = 200,
  parameter int NUM_SS  = 4,
  parameter int AW      = 8,
  parameter int LW      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [LW-1:0]     len,
  input  logic [DW-1:0]     rd_data,
  input  logic              tick,
  input  logic              rise_first,
  input  logic              rise_last,
  input  logic              fall_last,
  input  logic [DW-1:0]     rx_word,
  output logic              run_tick,
  output logic              run_shift,
  output logic              load,
  output logic [DW-1:0]     load_data,
  output logic [NUM_SS-1:0] ss_n,
  output logic              done,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_data
);

  eng_state_t        st;
  logic [LW-1:0]     len_q;
  logic [LW-1:0]     idx;
  logic [LW-1:0]     idx_nxt;
  logic [NUM_SS-1:0] mask_q;
  logic [DW-1:0]     pre_q;
  logic              rd_vld;
  logic              cmd_ok;
  logic              go_ok;
  logic              more;
  logic [LW-1:0]     len_eff;

  assign cmd_ok   = ((cmd >> NUM_SS) == '0) && (cmd[NUM_SS-1:0] != '0);
  assign go_ok    = cmd_ok && (len != '0);
  assign len_eff  = (len > LW'(MAX_LEN)) ? LW'(MAX_LEN) : len;
  assign idx_nxt  = idx + 1'b1;
  assign more     = idx_nxt < len_q;

  assign run_shift = (st == ST_XFER);
  assign run_tick  = (st == ST_XFER) || (st == ST_TRAIL);
  assign load      = (st == ST_LOAD) || (fall_last && more);
  assign load_data = (st == ST_LOAD) ? rd_data : pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      ss_n    <= '1;
      done    <= 1'b0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      idx     <= '0;
      len_q   <= '0;
      mask_q  <= '0;
      pre_q   <= '0;
      rd_vld  <= 1'b0;
    end else begin
      done   <= 1'b0;
      rd_en  <= 1'b0;
      wr_en  <= 1'b0;
      rd_vld <= rd_en;
      if (rd_vld) begin
        pre_q <= rd_data;
      end
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (go_ok) begin
              len_q   <= len_eff;
              mask_q  <= cmd[NUM_SS-1:0];
              idx     <= '0;
              rd_en   <= 1'b1;
              rd_addr <= '0;
              st      <= ST_FETCH;
            end else begin
              done <= 1'b1;
            end
          end
        end
        ST_FETCH: begin
          st <= ST_LOAD;
        end
        ST_LOAD: begin
          ss_n <= ~mask_q;
          st   <= ST_XFER;
        end
        ST_XFER: begin
          if (rise_first && more) begin
            rd_en   <= 1'b1;
            rd_addr <= idx_nxt[AW-1:0];
          end
          if (rise_last) begin
            wr_en   <= 1'b1;
            wr_addr <= idx[AW-1:0];
            wr_data <= rx_word;
          end
          if (fall_last) begin
            if (more) begin
              idx <= idx_nxt;
            end else begin
              st <= ST_TRAIL;
            end
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            ss_n <= '1;
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (rst) (st == ST_IDLE) |-> (ss_n == '1)); // R10
  AST_BAD_CMD_DONE: assert property (@(posedge clk) disable iff (rst) (st == ST_IDLE && start && !go_ok) |=> (done && ss_n == '1)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
  AST_WR_RANGE: assert property (@(posedge clk) disable iff (rst) wr_en |-> (int'(wr_addr) < MAX_LEN)); // R6
  AST_RD_RANGE: assert property (@(posedge clk) disable iff (rst) rd_en |-> (int'(rd_addr) < MAX_LEN)); // R6
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst) (st == ST_XFER && $past(st) == ST_XFER) |-> $stable(ss_n)); // R9

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int CLK_DIV = 4,
  parameter int MAX_LEN = 200,
  parameter int NUM_SS  = 4,
  parameter int DW      = 8,
  localparam int HALF   = CLK_DIV / 2,
  localparam int AW     = $clog2(MAX_LEN),
  localparam int LW     = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        cmd,
  input  logic [LW-1:0]     len,
  output logic              buf_rd_en,
  output logic [AW-1:0]     buf_rd_addr,
  input  logic [DW-1:0]     buf_rd_data,
  output logic              buf_wr_en,
  output logic [AW-1:0]     buf_wr_addr,
  output logic [DW-1:0]     buf_wr_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ss_n,
  output logic              done
);

  logic          tick;
  logic          run_tick;
  logic          run_shift;
  logic          load;
  logic [DW-1:0] load_data;
  logic          rise_first;
  logic          rise_last;
  logic          fall_last;
  logic [DW-1:0] rx_word;

  spi_cmd_tick #(
    .HALF (HALF)
  ) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (run_tick),
    .tick (tick)
  );

  spi_cmd_shifter #(
    .DW (DW)
  ) u_shift (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .run        (run_shift),
    .load       (load),
    .load_data  (load_data),
    .miso       (miso),
    .sclk       (sclk),
    .mosi       (mosi),
    .rise_first (rise_first),
    .rise_last  (rise_last),
    .fall_last  (fall_last),
    .rx_word    (rx_word)
  );

  spi_cmd_ctrl #(
    .DW      (DW),
    .MAX_LEN (MAX_LEN),
    .NUM_SS  (NUM_SS),
    .AW      (AW),
    .LW      (LW)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cmd        (cmd),
    .len        (len),
    .rd_data    (buf_rd_data),
    .tick       (tick),
    .rise_first (rise_first),
    .rise_last  (rise_last),
    .fall_last  (fall_last),
    .rx_word    (rx_word),
    .run_tick   (run_tick),
    .run_shift  (run_shift),
    .load       (load),
    .load_data  (load_data),
    .ss_n       (ss_n),
    .done       (done),
    .rd_en      (buf_rd_en),
    .rd_addr    (buf_rd_addr),
    .wr_en      (buf_wr_en),
    .wr_addr    (buf_wr_addr),
    .wr_data    (buf_wr_data)
  );

  AST_SCLK_NEEDS_SS: assert property (@(posedge clk) disable iff (rst) $rose(sclk) |-> (ss_n != '1)); // R7
  AST_WR_NEEDS_SS: assert property (@(posedge clk) disable iff (rst) buf_wr_en |-> (ss_n != '1)); // R5

endmodule

// File: tb/sim_spi_cmd_engine.sv
`timescale 1ns/1ps
module sim_spi_cmd_engine;

  localparam int CLK_DIV = 4;
  localparam int HALF    = CLK_DIV / 2;
  localparam int MAX_LEN = 200;
  localparam int NVEC    = 10;

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] len;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{8'h01, 8'd1,   8'd11},
    '{8'h0F, 8'd3,   8'd22},
    '{8'h05, 8'd2,   8'd33},
    '{8'h0A, 8'd5,   8'd44},
    '{8'h00, 8'd4,   8'd55},
    '{8'h10, 8'd4,   8'd66},
    '{8'hFF, 8'd1,   8'd77},
    '{8'h03, 8'd0,   8'd88},
    '{8'h08, 8'd250, 8'd99},
    '{8'h06, 8'd200, 8'd17}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] cmd = 8'h00;
  logic [7:0] len = 8'h00;
  logic       buf_rd_en;
  logic [7:0] buf_rd_addr;
  logic [7:0] buf_rd_data;
  logic       buf_wr_en;
  logic [7:0] buf_wr_addr;
  logic [7:0] buf_wr_data;
  logic       sclk;
  logic       mosi;
  logic       miso = 1'b0;
  logic [3:0] ss_n;
  logic       done;

  always #2.5 clk = ~clk;

  spi_cmd_engine #(.CLK_DIV(CLK_DIV), .MAX_LEN(MAX_LEN)) u0 (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .len(len),
    .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
    .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n), .done(done)
  );

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((s * 37 + i * 11 + 3) & 255);
  endfunction

  function automatic logic [7:0] rep(input int s, input int i);
    return 8'(((s * 53) ^ (i * 29 + 7)) & 255);
  endfunction

  // buffer model: one read port (1-cycle latency), one write port
  logic [7:0] mem [MAX_LEN];
  logic       fill_go = 1'b0;
  int         fill_seed = 0;
  always @(posedge clk) begin
    if (fill_go) begin
      for (int i = 0; i < MAX_LEN; i++) mem[i] <= pat(fill_seed, i);
    end else if (buf_wr_en) begin
      mem[buf_wr_addr] <= buf_wr_data;
    end
    if (buf_rd_en) buf_rd_data <= mem[buf_rd_addr];
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor and SPI slave model, sampled away from the active edge
  logic       mon_clr = 1'b0;
  int         seed_cur = 0;
  logic       prev_act, prev_sclk;
  int         rises, rise_no_ss, ss_falls, done_cnt, mask_glitch;
  int         t_ssf, t_ssr, t_r1, t_r2, t_fl, t_done;
  logic [3:0] mask_seen;
  logic [7:0] mb, sr;
  int         sbit, ridx;
  logic [7:0] cap [256];

  always @(negedge clk) begin
    if (mon_clr) begin
      prev_act = 1'b0; prev_sclk = 1'b0; rises = 0; rise_no_ss = 0; ss_falls = 0;
      done_cnt = 0; mask_glitch = 0; t_ssf = -1; t_ssr = -1; t_r1 = -1; t_r2 = -1;
      t_fl = -1; t_done = -1; mask_seen = 4'h0; mb = 8'h00; sr = 8'h00; sbit = 0; ridx = 0;
    end else begin
      if ((ss_n != 4'hF) && !prev_act) begin
        t_ssf = cyc; mask_seen = ~ss_n; ss_falls++;
        sbit = 0; ridx = 0; sr = rep(seed_cur, 0); miso = sr[7];
      end else if ((ss_n != 4'hF) && (~ss_n != mask_seen)) begin
        mask_glitch++;
      end
      if ((ss_n == 4'hF) && prev_act) t_ssr = cyc;
      if (sclk && !prev_sclk) begin
        rises++;
        if (ss_n == 4'hF) rise_no_ss++;
        if (rises == 1) t_r1 = cyc;
        if (rises == 2) t_r2 = cyc;
        mb = {mb[6:0], mosi};
        if (rises % 8 == 0 && rises <= 2048) cap[(rises / 8 - 1) % 256] = mb;
      end
      if (!sclk && prev_sclk) begin
        t_fl = cyc; sbit++;
        if (sbit == 8) begin sbit = 0; ridx++; sr = rep(seed_cur, ridx); end
        else sr = sr << 1;
        miso = sr[7];
      end
      if (done) begin done_cnt++; t_done = cyc; end
      prev_act  = (ss_n != 4'hF);
      prev_sclk = sclk;
    end
  end

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic prep(input int seed);
    @(posedge clk); #1;
    fill_go = 1'b1; fill_seed = seed; seed_cur = seed; mon_clr = 1'b1;
    @(posedge clk); #1;
    fill_go = 1'b0;
    @(negedge clk); #1;
    mon_clr = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic run_case(input logic [7:0] c, input logic [7:0] l, input int seed, input bit inject);
    int eff, t_start, guard, bad, badw;
    bit ok;
    ok  = (c >= 8'h01) && (c <= 8'h0F) && (l != 0);
    eff = ok ? ((l > MAX_LEN) ? MAX_LEN : int'(l)) : 0;
    prep(seed);
    start = 1'b1; cmd = c; len = l; t_start = cyc;
    @(posedge clk); #1;
    start = 1'b0;
    if (inject) begin
      repeat (12) @(posedge clk);
      #1; start = 1'b1; cmd = 8'h0C; len = 8'd5;
      @(posedge clk); #1; start = 1'b0;
    end
    guard = 0;
    while (done_cnt == 0 && guard < 20000) begin @(posedge clk); guard++; end
    repeat (40) @(posedge clk);
    #1;
    check(done_cnt == 1, "R8 done pulse count", done_cnt, 1);
    if (!ok) begin
      check(rises == 0, "R2 no SCLK on rejected start", rises, 0);
      check(ss_falls == 0, "R2 no select on rejected start", ss_falls, 0);
      check(t_done == t_start + 1, "R2 done one cycle after start", t_done - t_start, 1);
    end else begin
      check(ss_falls == 1, inject ? "R9 single transfer despite busy start" : "R1 one select phase", ss_falls, 1);
      check(mask_seen == c[3:0] && mask_glitch == 0, inject ? "R9 mask unchanged" : "R1 select mask", int'(mask_seen), int'(c[3:0]));
      check(rises == 8 * eff, "R6 SCLK rising count", rises, 8 * eff);
      check(rise_no_ss == 0, "R7 SCLK only while selected", rise_no_ss, 0);
      check(t_r1 - t_ssf == HALF, "R7 select lead", t_r1 - t_ssf, HALF);
      check(t_ssr - t_fl == HALF, "R7 select trail", t_ssr - t_fl, HALF);
      check(t_done == t_ssr, "R8 done with deselect", t_done, t_ssr);
      if (eff > 1) check(t_r2 - t_r1 == CLK_DIV, "R3 SCLK period", t_r2 - t_r1, CLK_DIV);
      bad = -1;
      for (int i = 0; i < eff; i++) if (cap[i] != pat(seed, i) && bad < 0) bad = i;
      check(bad < 0, "R4 MOSI bytes MSB first in order", (bad < 0) ? 0 : int'(cap[bad]), (bad < 0) ? 0 : int'(pat(seed, bad)));
      badw = -1;
      for (int i = 0; i < eff; i++) if (mem[i] != rep(seed, i) && badw < 0) badw = i;
      check(badw < 0, "R5 MISO byte written back", (badw < 0) ? 0 : int'(mem[badw]), (badw < 0) ? 0 : int'(rep(seed, badw)));
    end
    bad = -1;
    for (int i = eff; i < MAX_LEN; i++) if (mem[i] != pat(seed, i) && bad < 0) bad = i;
    check(bad < 0, "R6 slots past count untouched", bad, -1);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog R1 actual=%0d expected<%0d", cyc, 150000);
    finish_run();
  end

  initial begin
    mon_clr = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R10: reset state
    check(ss_n == 4'hF, "R10 ss_n in reset", int'(ss_n), 15);
    check(!sclk && !done, "R10 sclk/done low in reset", int'({sclk, done}), 0);
    check(!buf_rd_en && !buf_wr_en, "R10 no buffer access in reset", int'({buf_rd_en, buf_wr_en}), 0);
    rst = 1'b0;
    mon_clr = 1'b0;

    for (int v = 0; v < NVEC; v++) run_case(VEC[v].cmd, VEC[v].len, int'(VEC[v].seed), 1'b0);

    // R9: start strobe during a transfer
    run_case(8'h03, 8'd2, 123, 1'b1);

    // R10: reset in the middle of a transfer
    prep(7);
    start = 1'b1; cmd = 8'h0F; len = 8'd3;
    @(posedge clk); #1; start = 1'b0;
    repeat (20) @(posedge clk);
    #1; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(ss_n == 4'hF, "R10 ss_n after mid reset", int'(ss_n), 15);
    check(!sclk && !done, "R10 sclk/done after mid reset", int'({sclk, done}), 0);
    check(!buf_rd_en && !buf_wr_en, "R10 buffer idle after mid reset", int'({buf_rd_en, buf_wr_en}), 0);
    @(posedge clk); #1; rst = 1'b0;

    // engine still usable after reset
    run_case(8'h09, 8'd4, 31, 1'b0);

    finish_run();
  end

endmodule